// File: doc/BRIEF.md
# E1 Line Alarm Status and Simulation Unit

This block sits between an E1 receive framer and the host register file. It watches four live alarm levels (loss of signal, AIS, loss of frame, remote alarm), two slip strobes (receive and transmit), and six error-event strobes. The error events are framing error, code violation, CRC4 error, E-bit error, and two CRC-errored-block counts. Every alarm and slip latches a status bit that stays set until the host reads it. Every error event increments a 16-bit saturating counter, which is also cleared when the host reads it. A registered interrupt line is raised whenever any unmasked status bit is pending.

When `sim_en` is high, the block ignores the line and produces its own alarms. All four alarm levels read as active and all six status bits are set. The error counters advance on a tick from an internal divider whose period the host programs. The CRC-related counters stay at rest unless CRC multiframe operation is selected. When `sim_en` drops, the simulated levels vanish on the next cycle. The latched status bits and the accumulated counts remain until the host reads them. Host software can therefore exercise its whole alarm path without a faulty line.

Top module: `e1_alarm_status`

## Requirements
- R1: While `sim_en` is 1, the live-alarm register (address 1, bits [3:0] = LOS, AIS, LOF, RAI) reads 4'hF, and all six status bits become set. The line inputs `line_lvl`, `slip_evt` and `err_evt` have no effect on status or counters.
- R2: After `sim_en` returns to 0, the live-alarm register shows the real `line_lvl` from the next cycle on. Status bits set during simulation stay pending until the status register (address 0) is read.
- R3: While `sim_en` is 1, an internal tick fires once every `tick_period` cycles, with a period of 0 acting as 1. Each enabled counter gains exactly one count per tick, so a window of N cycles yields floor(N/period) counts.
- R4: When `crc_mf` is 0 (double-frame format), counters 2 to 5 (CRC4, E-bit, block count A, block count B) never change, whether from real or simulated events. Counters 0 and 1 (framing error, code violation) are unaffected by `crc_mf`.
- R5: A read takes effect at the clock edge where `rd_stb` is 1, and `rd_data` holds the result from the next cycle on. The address map is fixed:
  - 0: status, with bits 0..5 = LOS, AIS, LOF, RAI, receive slip, transmit slip.
  - 1: live alarm levels.
  - 2 to 7: counters 0 to 5.
- R6: Reading the status register or a counter clears it. If an event for that register arrives at the same edge as the read, the read returns the old value and the register then holds that new event (a counter holds 1).
- R7: Counters saturate at 65535 and never wrap.
- R8: `irq` is the OR of all status bits whose `irq_mask` bit is 0, registered one cycle after the status.
- R9: After reset, all status bits, counters, `rd_data` and `irq` are 0.
- R10: With `sim_en` at 0, a high `line_lvl` bit or a `slip_evt` strobe sets the matching status bit, and each `err_evt` strobe adds one to its counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sim_en | input | 1 | Alarm simulation enable |
| crc_mf | input | 1 | 1 = CRC4 multiframe, 0 = double-frame format |
| tick_period | input | 16 | Simulation tick period in cycles (0 acts as 1) |
| line_lvl | input | 4 | Live alarm levels: LOS, AIS, LOF, RAI |
| slip_evt | input | 2 | Slip strobes: bit 0 receive, bit 1 transmit |
| err_evt | input | 6 | Error-event strobes for counters 0..5 |
| irq_mask | input | 6 | Per-status interrupt mask, 1 = masked |
| rd_stb | input | 1 | Read strobe (clears the addressed register) |
| rd_addr | input | 3 | Read address |
| rd_data | output | 16 | Registered read data |
| irq | output | 1 | Registered interrupt request |

## Verification
The embedded assertions check the following on every cycle:
- Counters step by at most one and hold at full scale.
- A read that coincides with an event leaves exactly one count behind.
- Pending status bits never drop without a read.
- The CRC counters stay frozen in double-frame mode.
- The live-alarm readout is all ones while simulating.
- The tick never fires on consecutive cycles for periods above one.

Only the bench scenarios can show the end-to-end figures:
- The exact count reached over a simulation window for each period and format.
- That real line events are ignored during simulation.
- That statuses outlive the simulation, and the interrupt masking.
- Saturation after more than 65535 ticks.

// File: rtl/e1_alarm_pkg.sv
package e1_alarm_pkg;
  localparam int NUM_LVL  = 4;  // LOS, AIS, LOF, RAI
  localparam int NUM_SLIP = 2;  // receive slip, transmit slip
  localparam int NUM_STAT = NUM_LVL + NUM_SLIP;
  localparam int NUM_CNT  = 6;  // FE, CV, CRC4, EBIT, block A, block B
  localparam int FIRST_CRC_CNT = 2;
  localparam int ADDR_W   = 3;
  localparam int DATA_W   = 16;

  localparam logic [ADDR_W-1:0] ADDR_STATUS = 3'd0;
  localparam logic [ADDR_W-1:0] ADDR_LIVE   = 3'd1;
  localparam int                ADDR_CNT0   = 2;

  // Counters that only apply in CRC multiframe mode
  function automatic bit needs_crc(input int idx);
    return idx >= FIRST_CRC_CNT;
  endfunction
endpackage

// File: rtl/sim_tick_gen.sv
module sim_tick_gen #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         run,
  input  logic [W-1:0] period,
  output logic         tick
);
  logic [W-1:0] cnt_q;
  logic [W-1:0] lim;

  assign lim  = (period == '0) ? '0 : period - 1'b1;
  assign tick = run && (cnt_q >= lim);

  always_ff @(posedge clk) begin
    if (rst || !run || tick) cnt_q <= '0;
    else                     cnt_q <= cnt_q + 1'b1;
  end

  // R3: with a period above one, a tick is followed by a quiet cycle
  assert_tick_spacing_R3: assert property (@(posedge clk) disable iff (rst)
    (tick && lim != '0) |=> (!tick || lim != $past(lim)));
endmodule

// File: rtl/sat_counter.sv
module sat_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         evt,
  input  logic         clr,
  output logic [W-1:0] q
);
  localparam logic [W-1:0] MAX = '1;

  always_ff @(posedge clk) begin
    if (rst)                  q <= '0;
    else if (clr)             q <= {{(W-1){1'b0}}, evt};
    else if (evt && q != MAX) q <= q + 1'b1;
  end

  assert_no_wrap_R7: assert property (@(posedge clk) disable iff (rst)
    (q == MAX && !clr) |=> q == MAX);
  assert_single_step_R3: assert property (@(posedge clk) disable iff (rst)
    !clr |=> (q == $past(q) || q == $past(q) + 1'b1));
  assert_keep_event_R6: assert property (@(posedge clk) disable iff (rst)
    (clr && evt) |=> q == {{(W-1){1'b0}}, 1'b1});
endmodule

// File: rtl/status_latch.sv
module status_latch #(
  parameter int N = 6
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set,
  input  logic         clr,
  output logic [N-1:0] st
);
  always_ff @(posedge clk) begin
    if (rst) st <= '0;
    else     st <= (clr ? '0 : st) | set;
  end

  assert_sticky_R2: assert property (@(posedge clk) disable iff (rst)
    !$past(clr) |-> ((st & $past(st)) == $past(st)));
  assert_set_wins_R6: assert property (@(posedge clk) disable iff (rst)
    |set |=> ((st & $past(set)) == $past(set)));
endmodule

// File: rtl/e1_alarm_status.sv
module e1_alarm_status
  import e1_alarm_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int TICK_W = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                sim_en,
  input  logic                crc_mf,
  input  logic [TICK_W-1:0]   tick_period,
  input  logic [NUM_LVL-1:0]  line_lvl,
  input  logic [NUM_SLIP-1:0] slip_evt,
  input  logic [NUM_CNT-1:0]  err_evt,
  input  logic [NUM_STAT-1:0] irq_mask,
  input  logic                rd_stb,
  input  logic [ADDR_W-1:0]   rd_addr,
  output logic [DATA_W-1:0]   rd_data,
  output logic                irq
);
  logic                tick;
  logic [NUM_LVL-1:0]  lvl_eff;
  logic [NUM_SLIP-1:0] slip_eff;
  logic [NUM_STAT-1:0] status;
  logic                stat_clr;
  logic [NUM_CNT-1:0]  cnt_evt;
  logic [NUM_CNT-1:0]  cnt_clr;
  logic [CNT_W-1:0]    cnt [NUM_CNT];
  logic [DATA_W-1:0]   rd_mux;

  sim_tick_gen #(.W(TICK_W)) i_tick (
    .clk(clk), .rst(rst), .run(sim_en), .period(tick_period), .tick(tick)
  );

  // Simulation replaces every line source
  assign lvl_eff  = sim_en ? '1 : line_lvl;
  assign slip_eff = sim_en ? '1 : slip_evt;
  assign stat_clr = rd_stb && (rd_addr == ADDR_STATUS);

  status_latch #(.N(NUM_STAT)) i_stat (
    .clk(clk), .rst(rst), .set({slip_eff, lvl_eff}), .clr(stat_clr), .st(status)
  );

  for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
    localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(ADDR_CNT0 + i);
    logic mode_ok;
    if (needs_crc(i)) begin : g_crc
      assign mode_ok = crc_mf;
    end else begin : g_any
      assign mode_ok = 1'b1;
    end
    assign cnt_evt[i] = mode_ok && (sim_en ? tick : err_evt[i]);
    assign cnt_clr[i] = rd_stb && (rd_addr == MY_ADDR);

    sat_counter #(.W(CNT_W)) i_ctr (
      .clk(clk), .rst(rst), .evt(cnt_evt[i]), .clr(cnt_clr[i]), .q(cnt[i])
    );

    if (needs_crc(i)) begin : g_chk
      assert_crc_frozen_R4: assert property (@(posedge clk) disable iff (rst)
        (!crc_mf && !cnt_clr[i]) |=> cnt[i] == $past(cnt[i]));
    end
  end

  always_comb begin
    rd_mux = '0;
    if (rd_addr == ADDR_STATUS)      rd_mux = DATA_W'(status);
    else if (rd_addr == ADDR_LIVE)   rd_mux = DATA_W'(lvl_eff);
    else begin
      for (int k = 0; k < NUM_CNT; k++)
        if (rd_addr == ADDR_W'(ADDR_CNT0 + k)) rd_mux = DATA_W'(cnt[k]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
      irq     <= 1'b0;
    end else begin
      if (rd_stb) rd_data <= rd_mux;
      irq <= |(status & ~irq_mask);
    end
  end

  assert_live_forced_R1: assert property (@(posedge clk) disable iff (rst)
    (sim_en && rd_stb && rd_addr == ADDR_LIVE) |=> rd_data[NUM_LVL-1:0] == '1);
  assert_irq_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    ($past(status) == '0) |-> !irq);
endmodule

// File: tb/test_e1_alarm_status.sv
module test_e1_alarm_status;
  logic        clk = 1'b0;
  logic        rst;
  logic        sim_en;
  logic        crc_mf;
  logic [15:0] tick_period;
  logic [3:0]  line_lvl;
  logic [1:0]  slip_evt;
  logic [5:0]  err_evt;
  logic [5:0]  irq_mask;
  logic        rd_stb;
  logic [2:0]  rd_addr;
  logic [15:0] rd_data;
  logic        irq;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;  // 50 MHz

  e1_alarm_status i_e1_alarm_status (
    .clk(clk), .rst(rst), .sim_en(sim_en), .crc_mf(crc_mf),
    .tick_period(tick_period), .line_lvl(line_lvl), .slip_evt(slip_evt),
    .err_evt(err_evt), .irq_mask(irq_mask), .rd_stb(rd_stb),
    .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq)
  );

  typedef struct packed {
    logic        sim;
    logic        crc;
    logic [15:0] period;
    logic [15:0] cycles;
    logic [15:0] exp_fe;
    logic [15:0] exp_crc;
  } vec_t;

  // Window of cycles with real events strobed every cycle
  localparam vec_t VECS [7] = '{
    '{1'b0, 1'b1, 16'd1,    16'd5,  16'd5, 16'd5},  // R10 real counting
    '{1'b0, 1'b0, 16'd1,    16'd7,  16'd7, 16'd0},  // R4 double-frame
    '{1'b1, 1'b1, 16'd1,    16'd6,  16'd6, 16'd6},  // R3 tick every cycle
    '{1'b1, 1'b1, 16'd4,    16'd12, 16'd3, 16'd3},  // R3 period 4
    '{1'b1, 1'b0, 16'd3,    16'd10, 16'd3, 16'd0},  // R4 sim double-frame
    '{1'b1, 1'b1, 16'd0,    16'd4,  16'd4, 16'd4},  // R3 period 0 acts as 1
    '{1'b1, 1'b1, 16'd1000, 16'd10, 16'd0, 16'd0}   // R1 real events ignored
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk);
    rd_stb = 1'b1; rd_addr = a;
    @(posedge clk);
    @(negedge clk);
    rd_stb = 1'b0;
    d = rd_data;
  endtask

  task automatic clear_all();
    logic [15:0] d;
    for (int a = 0; a < 8; a++) rd(3'(a), d);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [15:0] d;
    rst = 1'b1; sim_en = 1'b0; crc_mf = 1'b1; tick_period = 16'd1;
    line_lvl = '0; slip_evt = '0; err_evt = '0; irq_mask = '0;
    rd_stb = 1'b0; rd_addr = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R9 reset state
    chk("R9 irq", {15'd0, irq}, 16'd0);
    chk("R9 rd_data", rd_data, 16'd0);
    rd(3'd0, d); chk("R9 status", d, 16'd0);
    rd(3'd2, d); chk("R9 counter0", d, 16'd0);

    // Vector table: R3 R4 R10 R1
    foreach (VECS[v]) begin
      @(negedge clk);
      crc_mf = VECS[v].crc; tick_period = VECS[v].period;
      sim_en = VECS[v].sim; err_evt = '1;
      repeat (VECS[v].cycles) @(negedge clk);
      sim_en = 1'b0; err_evt = '0;
      rd(3'd2, d); chk($sformatf("R3/R10 vec%0d FE count", v), d, VECS[v].exp_fe);
      rd(3'd4, d); chk($sformatf("R4 vec%0d CRC count", v), d, VECS[v].exp_crc);
      clear_all();
    end
    crc_mf = 1'b1; tick_period = 16'd1;

    // R1 live register forced during simulation, real levels low
    @(negedge clk); sim_en = 1'b1;
    rd(3'd1, d); chk("R1 live during sim", d, 16'h000F);
    @(negedge clk); sim_en = 1'b0;
    // R2 live drops at once, status stays pending until read
    rd(3'd1, d); chk("R2 live after sim", d, 16'h0000);
    repeat (5) @(negedge clk);
    rd(3'd0, d); chk("R2 status pending", d, 16'h003F);
    rd(3'd0, d); chk("R6 status cleared by read", d, 16'h0000);
    clear_all();

    // R10 real level and slip outside simulation
    @(negedge clk); line_lvl = 4'b0010;
    rd(3'd1, d); chk("R10 live AIS", d, 16'h0002);
    @(negedge clk); line_lvl = 4'b0000; slip_evt = 2'b01;
    @(negedge clk); slip_evt = 2'b00;
    rd(3'd0, d); chk("R10 status AIS and rx slip", d, 16'h0012);

    // R6 read and event in the same cycle
    @(negedge clk); err_evt = 6'b000001;
    repeat (3) @(negedge clk);
    rd_stb = 1'b1; rd_addr = 3'd2;
    @(negedge clk);
    rd_stb = 1'b0; err_evt = '0;
    chk("R5/R6 read returns old value", rd_data, 16'd3);
    rd(3'd2, d); chk("R6 event kept after clear", d, 16'd1);

    // R8 interrupt masking
    clear_all();
    @(negedge clk); sim_en = 1'b1; irq_mask = 6'h3F;
    repeat (2) @(negedge clk);
    sim_en = 1'b0;
    repeat (2) @(negedge clk);
    chk("R8 all masked", {15'd0, irq}, 16'd0);
    irq_mask = 6'h3E;
    @(negedge clk); @(negedge clk);
    chk("R8 LOS unmasked", {15'd0, irq}, 16'd1);
    rd(3'd0, d);
    @(negedge clk);
    chk("R8 irq drops after status read", {15'd0, irq}, 16'd0);
    clear_all();

    // R7 saturation
    @(negedge clk); sim_en = 1'b1;
    repeat (65540) @(negedge clk);
    sim_en = 1'b0;
    rd(3'd2, d); chk("R7 saturated", d, 16'hFFFF);
    rd(3'd2, d); chk("R7 cleared after saturation", d, 16'h0000);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule